// File: doc/BRIEF.md
# Peripheral Clock Divider with Source Select

This block derives the clock for one peripheral from a choice of source clocks. Each source is represented by a single-cycle enable strobe in the system clock domain, so the whole block runs on one clock. The selected strobe stream first passes a power-of-two prescaler (divide by 2^P) and then a linear divider (divide by M+1). The result is a one-cycle strobe on `clk_out`, issued once per output period.

Software controls everything through one 32-bit configuration word. It is written with a write-enable and data bus and can always be read back. The word holds an output enable, the source select, the prescaler exponent and the linear divide factor. A new source, P or M is not applied straight away. The active settings are updated only at the end of an output period, or while the block is disabled. This keeps any period from being cut short.

Top module: `modclk_gen`

## Requirements
- R1: After a synchronous active-low reset, `cfg_rdata` reads 0 and `clk_out` is low.
- R2: Only the defined bits of the configuration word are kept: bit 31, select bits 24 upward (SEL_W bits, default 2), bits 17:16 and bits 3:0. All other bits read back 0 whatever is written; with the default build the writable mask is 0x8303000F.
- R3: When bit 31 (enable) is 0, the divider counters return to zero and `clk_out` is low from the second clock edge after the write that clears it.
- R4: The select field (bits 24 upward) chooses which bit of `src_tick` feeds the dividers; index k selects `src_tick[k]`.
- R5: The prescaler exponent P in bits 17:16 divides the selected strobe count by 2^P.
- R6: The linear factor M in bits 3:0 divides the prescaler output by M+1.
- R7: `clk_out` pulses for one cycle once every 2^P x (M+1) selected source strobes, one clock after the strobe that completes the period.
- R8: With P=0 and M=0, `clk_out` repeats every selected strobe, delayed by one clock.
- R9: A write that changes select, P or M while running takes effect only after the current output pulse has fired; the period in progress completes with the old settings.
- R10: After enable is set, the first output pulse comes after a full period counted from the first strobe sampled once the enable is active, using the fields written with the enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration word readback |
| src_tick | input | 2^SEL_W | One enable strobe per source clock |
| clk_out | output | 1 | Divided output strobe |

## Verification
On every cycle the assertions check four things. Undefined register bits stay zero. The output is low once the enable has been seen clear. The active settings do not move except at a period boundary or while disabled. The linear counter never passes its limit. The exact period for each combination of source, P and M can only be shown by the bench scenarios. So can the point at which a mid-period reconfiguration takes effect and the latency of the first pulse after enabling. For these, a strobe-counting reference model is compared with `clk_out` and `cfg_rdata` on every clock.

// File: rtl/modclk_pkg.sv
// Package: field positions and the active-settings type shared by the
// clock divider blocks. Assumes a 32-bit configuration word.
package modclk_pkg;
    localparam int EN_BIT  = 31;
    localparam int SEL_LSB = 24;
    localparam int SEL_MAX = 4;
    localparam int P_LSB   = 16;
    localparam int P_W     = 2;
    localparam int M_LSB   = 0;
    localparam int M_W     = 4;
    // prescaler count reaches 2^(2^P_W - 1) - 1
    localparam int PC_W    = (1 << P_W) - 1;

    typedef struct packed {
        logic               en;
        logic [SEL_MAX-1:0] sel;
        logic [P_W-1:0]     p;
        logic [M_W-1:0]     m;
    } act_t;
endpackage

// File: rtl/modclk_regs.sv
// Configuration word and active-settings register.
// Holds the software-visible word (undefined bits forced to zero) and a
// second copy of the divider settings. That copy reloads only while
// disabled or when the divider fires. Assumes SEL_W <= SEL_MAX.
module modclk_regs
    import modclk_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    input  logic        fire,
    output logic [31:0] rdata,
    output act_t        act
);
    localparam logic [31:0] MASK = (32'h1 << EN_BIT)
                                 | (((32'h1 << SEL_W) - 32'h1) << SEL_LSB)
                                 | (((32'h1 << P_W) - 32'h1) << P_LSB)
                                 | (((32'h1 << M_W) - 32'h1) << M_LSB);

    logic [31:0] cfg_q;
    act_t        act_q;

    // software word: capture masked write data
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (we)
            cfg_q <= wdata & MASK;
    end

    // active settings: enable tracks the word, fields reload at a boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else begin
            act_q.en <= cfg_q[EN_BIT];
            if (!act_q.en || fire) begin
                act_q.sel <= SEL_MAX'(cfg_q[SEL_LSB +: SEL_W]);
                act_q.p   <= cfg_q[P_LSB +: P_W];
                act_q.m   <= cfg_q[M_LSB +: M_W];
            end
        end
    end

    assign rdata = cfg_q;
    assign act   = act_q;
endmodule

// File: rtl/modclk_srcmux.sv
// Source strobe selector: passes the strobe whose index equals sel.
// Assumes sel values beyond N_SRC-1 never occur (masked upstream).
module modclk_srcmux
    import modclk_pkg::*;
#(
    parameter int N_SRC = 4
) (
    input  logic [N_SRC-1:0]   src_tick,
    input  logic [SEL_MAX-1:0] sel,
    output logic               tick
);
    logic [N_SRC-1:0] hit;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign hit[g] = src_tick[g] && (sel == SEL_MAX'(g));
    end

    // one-hot select collapses to a single strobe
    assign tick = |hit;
endmodule

// File: rtl/modclk_div.sv
// Two-stage divider: a 2^P prescaler counter, then a (M+1) counter.
// fire marks the strobe that completes an output period; out_q is that
// strobe registered. Both counters clear whenever en is low.
module modclk_div
    import modclk_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           tick,
    input  logic [P_W-1:0] p,
    input  logic [M_W-1:0] m,
    output logic           fire,
    output logic [M_W-1:0] div_cnt,
    output logic           out_q
);
    logic [PC_W-1:0] pre_cnt;
    logic [PC_W-1:0] pre_lim;
    logic [M_W-1:0]  div_q;
    logic            pre_last;
    logic            div_last;

    // prescaler terminal count from the exponent
    always_comb begin
        pre_lim  = PC_W'((32'd1 << p) - 32'd1);
        pre_last = (pre_cnt == pre_lim);
        div_last = (div_q == m);
        fire     = en && tick && pre_last && div_last;
    end

    // prescaler counter advances on each selected strobe
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            pre_cnt <= '0;
        else if (tick)
            pre_cnt <= pre_last ? '0 : pre_cnt + PC_W'(1);
    end

    // linear counter advances on each prescaler wrap
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            div_q <= '0;
        else if (tick && pre_last)
            div_q <= div_last ? '0 : div_q + M_W'(1);
    end

    // output strobe register
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= 1'b0;
        else
            out_q <= fire;
    end

    assign div_cnt = div_q;
endmodule

// File: rtl/modclk_gen.sv
// Peripheral clock divider top. Selects one of 2^SEL_W source strobes,
// divides by 2^P then by M+1, and gates the result with the enable bit.
// Single clock domain; sources are enable strobes, not clocks.
module modclk_gen
    import modclk_pkg::*;
#(
    parameter  int SEL_W = 2,
    localparam int N_SRC = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic [N_SRC-1:0] src_tick,
    output logic             clk_out
);
    act_t           act_q;
    logic           fire;
    logic           sel_tick;
    logic [M_W-1:0] div_cnt;

    modclk_regs #(.SEL_W(SEL_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .fire  (fire),
        .rdata (cfg_rdata),
        .act   (act_q)
    );

    modclk_srcmux #(.N_SRC(N_SRC)) u_mux (
        .src_tick (src_tick),
        .sel      (act_q.sel),
        .tick     (sel_tick)
    );

    modclk_div u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (act_q.en),
        .tick    (sel_tick),
        .p       (act_q.p),
        .m       (act_q.m),
        .fire    (fire),
        .div_cnt (div_cnt),
        .out_q   (clk_out)
    );
endmodule

// File: rtl/modclk_gen_chk.sv
// Property checker for modclk_gen, attached by bind below.
module modclk_gen_chk
    import modclk_pkg::*;
#(
    parameter  int SEL_W = 2,
    localparam int N_SRC = 1 << SEL_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      cfg_rdata,
    input logic [N_SRC-1:0] src_tick,
    input logic             clk_out,
    input act_t             act,
    input logic             fire,
    input logic [M_W-1:0]   div_cnt
);
    localparam logic [31:0] DEF_BITS = (32'h1 << EN_BIT)
                                     | (((32'h1 << SEL_W) - 32'h1) << SEL_LSB)
                                     | (((32'h1 << P_W) - 32'h1) << P_LSB)
                                     | (((32'h1 << M_W) - 32'h1) << M_LSB);

    a_r2_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~DEF_BITS) == 32'h0);

    a_r3_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        !act.en |=> !clk_out);

    a_r9_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        (act.en && !fire) |=> $stable({act.sel, act.p, act.m}));

    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        act.en |-> (div_cnt <= act.m));

    a_r7_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        clk_out |-> $past(|src_tick));
endmodule

bind modclk_gen modclk_gen_chk #(.SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rdata (cfg_rdata),
    .src_tick  (src_tick),
    .clk_out   (clk_out),
    .act       (act_q),
    .fire      (fire),
    .div_cnt   (div_cnt)
);

// File: tb/sim_modclk_gen.sv
// Bench: behavioural reference model counting selected strobes per period,
// compared against clk_out and cfg_rdata on every clock.
module sim_modclk_gen;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MASK = 32'h8303000F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [3:0]  src_tick = '0;
    logic        clk_out;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference model state
    logic [31:0] m_cfg = '0;
    int m_en = 0, m_sel = 0, m_p = 0, m_m = 0, m_cnt = 0;
    bit m_out = 0;
    int cyc_n = 0;
    logic [7:0] lfsr = 8'hA5;

    always #(CLK_PERIOD/2) clk = ~clk;

    modclk_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .src_tick  (src_tick),
        .clk_out   (clk_out)
    );

    task automatic model_edge();
        bit fire;
        if (!rst_n) begin
            m_cfg = '0; m_en = 0; m_sel = 0; m_p = 0; m_m = 0;
            m_cnt = 0; m_out = 0;
            return;
        end
        fire = (m_en != 0) && src_tick[m_sel] &&
               (m_cnt + 1 == (1 << m_p) * (m_m + 1));
        if (m_en == 0)
            m_cnt = 0;
        else if (src_tick[m_sel])
            m_cnt = fire ? 0 : m_cnt + 1;
        if (m_en == 0 || fire) begin
            m_sel = int'(m_cfg[25:24]);
            m_p   = int'(m_cfg[17:16]);
            m_m   = int'(m_cfg[3:0]);
        end
        m_en  = int'(m_cfg[31]);
        m_out = fire;
        if (cfg_we)
            m_cfg = cfg_wdata & MASK;
    endtask

    task automatic cyc(input bit we, input logic [31:0] wd);
        @(negedge clk);
        n_chk += 2;
        if (clk_out !== m_out) begin
            n_bad++;
            $display("FAIL %s clk_out: actual=%b expected=%b t=%0t", cur_req, clk_out, m_out, $time);
        end
        if (cfg_rdata !== m_cfg) begin
            n_bad++;
            $display("FAIL %s cfg_rdata: actual=%h expected=%h t=%0t", cur_req, cfg_rdata, m_cfg, $time);
        end
        cfg_we    = we;
        cfg_wdata = wd;
        src_tick  = {lfsr[0], (cyc_n % 3) == 0, (cyc_n % 2) == 0, 1'b1};
        lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        cyc_n++;
        @(posedge clk);
        model_edge();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, '0);
    endtask

    task automatic wr(input logic [31:0] wd, input int n);
        cyc(1'b1, wd);
        run(n);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        cur_req = "R1";          // reset state
        run(3);
        rst_n = 1'b1;
        run(4);
        cur_req = "R2";          // undefined bits dropped, readback of mask
        wr(32'hFFFF_FFFF, 40);
        wr(32'h7CFC_FFF0, 3);    // only undefined + no enable bits
        wr(32'h8F00_0000, 6);    // select bits above SEL_W masked off
        cur_req = "R3";          // disabled output low
        wr(32'h0000_0000, 10);
        cur_req = "R8";          // P=0, M=0 follows strobe
        wr(32'h8000_0000, 12);
        cur_req = "R4";          // source index select
        wr(32'h8100_0000, 12);
        wr(32'h8200_0000, 12);
        wr(32'h8300_0000, 20);
        cur_req = "R5";          // prescaler 2^P
        wr(32'h8002_0000, 30);
        wr(32'h8003_0000, 40);
        cur_req = "R6";          // linear M+1
        wr(32'h8200_0005, 60);
        cur_req = "R7";          // combined period
        wr(32'h8301_0003, 90);
        cur_req = "R9";          // change mid period
        wr(32'h8003_0002, 20);
        wr(32'h8000_0001, 60);
        cur_req = "R3";          // disable while running
        wr(32'h0003_0002, 8);
        cur_req = "R10";         // enable with new fields
        wr(32'h8101_0001, 40);
        finish_run();
    end
endmodule